// File: doc/BRIEF.md
# Software-Strobed Three-Wire Serial Shifter

This block is a register-mapped serial port for a processor. It has no baud generator of its own. Software makes every serial clock edge by writing strobe bits into a control register. One eight-bit data register serves as both the transmit buffer and the shift register. Before a transfer, software places the outgoing byte in it. After sixteen clock-edge strobes, the same register holds the byte received from the peripheral.

An edge counter advances once per clock toggle. It wraps after sixteen toggles, which is one byte, and sets a sticky overflow flag that software polls and clears. The serial clock has no delay beyond one register. When software writes the control register every second system cycle, alternating a toggle-only value with a toggle-plus-shift value, the serial clock runs at a quarter of the system clock.

Register map, by write/read address: 0 is control, 1 is status, 2 is data, and 3 reads as zero. Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `strobe_serial_shifter`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00, and `sck` and `sdo` are low.
- R2: A control write with bit 0 (toggle strobe) set in enabled mode inverts `sck` and increments the 4-bit edge count, both visible one clock after the write.
- R3: A toggle that moves the count from 15 to 0 sets the overflow flag (status bit 7). The flag stays set until software clears it.
- R4: A status write loads the edge count from bits 3:0. A one in bit 7 clears the overflow flag; a zero in bit 7 leaves the flag unchanged.
- R5: The data register shifts one position only when a control write sets bit 1 (shift strobe) together with bit 0. Bit 1 written alone leaves the data register, `sck` and the count unchanged.
- R6: `sdo` always shows bit 7 of the data register, so the most significant bit goes out first. A write to address 2 loads the whole register.
- R7: `sdi` is captured when a toggle drives `sck` from low to high. The captured bit enters at bit 0 on the next shift, so after a full transfer the data register holds the received byte.
- R8: Reading the control register returns bits 5:4 (wire mode) and 3:2 (clock source) as last written, and bits 1:0 as zero.
- R9: Strobes act only when the same write selects three-wire mode (bits 5:4 = 01) and software clocking (bits 3:2 = 00). Under any other mode or source, strobes leave `sck`, the count and the data unchanged.
- R10: When control writes arrive every second clock, alternating 0x11 and 0x13, `sck` is high for two clocks and low for two clocks, a period of four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 data) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, MSB of the data register |
| sck | output | 1 | Serial clock out |

## Verification
A stuck or skipped edge count shows up at the end of a byte. The overflow flag appears one toggle early or late, or not at all, and the status read shows this right after the write concerned. A shift that fires on the wrong strobe, or misses its sample, changes `sdo` within one clock. It also leaves a wrong received byte in the data register, readable after the sixteenth strobe. A strobe that is not gated by mode shows up as an `sck` change one clock after the write that should have been ignored.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int BIT_TOGGLE = 0;
  localparam int BIT_SHIFT  = 1;
  localparam int SRC_LO     = 2;
  localparam int MODE_LO    = 4;

  localparam logic [1:0] MODE_THREE_WIRE = 2'b01;
  localparam logic [1:0] SRC_SOFT_STROBE = 2'b00;

  // True when a control value enables software-strobed three-wire clocking
  function automatic logic strobe_enabled(input logic [7:0] ctrl);
    return (ctrl[MODE_LO+1:MODE_LO] == MODE_THREE_WIRE) &&
           (ctrl[SRC_LO+1:SRC_LO] == SRC_SOFT_STROBE);
  endfunction
endpackage

// File: rtl/sss_ctrl_decode.sv
module sss_ctrl_decode
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [1:0] mode_q,
  output logic [1:0] src_q,
  output logic       toggle_fire,
  output logic       shift_fire
);
  logic ctrl_hit;
  logic enabled;

  assign ctrl_hit    = wr_en && (wr_addr == ADDR_CTRL);
  assign enabled     = strobe_enabled(wr_data);
  assign toggle_fire = ctrl_hit && enabled && wr_data[BIT_TOGGLE];
  assign shift_fire  = toggle_fire && wr_data[BIT_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      src_q  <= '0;
    end else if (ctrl_hit) begin
      mode_q <= wr_data[MODE_LO+1:MODE_LO];
      src_q  <= wr_data[SRC_LO+1:SRC_LO];
    end
  end
endmodule

// File: rtl/sss_edge_counter.sv
module sss_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_flag,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             wrap_evt
);
  // Count plus carry; the carry marks the wrap to zero
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W:0] nxt;
  assign nxt      = advance(cnt_q);
  assign wrap_evt = step && nxt[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load)      cnt_q <= load_val;
      else if (step) cnt_q <= nxt[CNT_W-1:0];
      if (wrap_evt)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sss_shift_reg.sv
module sss_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              toggle,
  input  logic              shift,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_q,
  output logic              sck_q,
  output logic              rise_evt
);
  logic sample_q;

  assign rise_evt = toggle && !sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      sck_q    <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      if (toggle)   sck_q    <= ~sck_q;
      if (rise_evt) sample_q <= sdi;
      if (load)       data_q <= load_val;
      else if (shift) data_q <= {data_q[DATA_W-2:0], sample_q};
    end
  end
endmodule

// File: rtl/strobe_serial_shifter.sv
module strobe_serial_shifter
  import sss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sdi,
  output logic              sdo,
  output logic              sck
);
  localparam int CNT_W  = $clog2(2 * DATA_W);
  localparam int STAT_PAD = DATA_W - 1 - CNT_W;

  logic [1:0]        mode_q, src_q;
  logic              toggle_fire, shift_fire;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q, wrap_evt, rise_evt;
  logic [DATA_W-1:0] data_q;
  logic              stat_wr, data_wr;

  assign stat_wr = wr_en && (wr_addr == ADDR_STAT);
  assign data_wr = wr_en && (wr_addr == ADDR_DATA);

  sss_ctrl_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data[7:0]), .mode_q(mode_q), .src_q(src_q),
    .toggle_fire(toggle_fire), .shift_fire(shift_fire)
  );

  sss_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(toggle_fire), .load(stat_wr),
    .load_val(wr_data[CNT_W-1:0]), .clr_flag(stat_wr && wr_data[DATA_W-1]),
    .cnt_q(cnt_q), .flag_q(flag_q), .wrap_evt(wrap_evt)
  );

  sss_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(data_wr), .load_val(wr_data),
    .toggle(toggle_fire), .shift(shift_fire), .sdi(sdi),
    .data_q(data_q), .sck_q(sck), .rise_evt(rise_evt)
  );

  assign sdo = data_q[DATA_W-1];

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTRL: rd_data[5:0] = {mode_q, src_q, 2'b00};
      ADDR_STAT: rd_data = {flag_q, {STAT_PAD{1'b0}}, cnt_q};
      ADDR_DATA: rd_data = data_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              toggle_fire,
  input logic              shift_fire,
  input logic              wrap_evt,
  input logic              flag_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              sck,
  input logic [DATA_W-1:0] data_q,
  input logic              stat_wr,
  input logic              data_wr,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_fire |=> (sck != $past(sck)));

  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_fire && !stat_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_idle_sck_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_fire |=> $stable(sck));

  assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);

  assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap_evt));

  assert_shift_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |-> toggle_fire);

  assert_shift_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !data_wr) |=> (data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0])));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_fire && !data_wr) |=> $stable(data_q));

  assert_strobe_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[1:0] == 2'b00));
endmodule

bind strobe_serial_shifter sss_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .toggle_fire(toggle_fire), .shift_fire(shift_fire),
  .wrap_evt(wrap_evt), .flag_q(flag_q), .cnt_q(cnt_q), .sck(sck),
  .data_q(data_q), .stat_wr(stat_wr), .data_wr(data_wr),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/strobe_serial_shifter_tb.sv
module strobe_serial_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sdi = 1'b0;
  logic       sdo, sck;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit busy = 1'b0;
  bit done = 1'b0;

  // kind 0..2: register read, 3: {sck,sdo}, 4: sck only
  typedef struct {
    int         kind;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  strobe_serial_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sdi(sdi), .sdo(sdo), .sck(sck)
  );

  always @(posedge clk) cycles <= cycles + 1;

  task automatic push(input int kind, input logic [7:0] val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() != 0 || busy) #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      exp_t e;
      logic [7:0] act;
      while (sb_q.size() == 0) #1;
      busy = 1'b1;
      e = sb_q.pop_front();
      if (e.kind < 3) rd_addr = e.kind[1:0];
      #1;
      if (e.kind < 3)       act = rd_data;
      else if (e.kind == 3) act = {6'b0, sck, sdo};
      else                  act = {7'b0, sck};
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s actual=%02h expected=%02h", e.tag, act, e.val);
      end
      busy = 1'b0;
    end
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx, rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    push(0, 8'h00, "R1 ctrl"); push(1, 8'h00, "R1 stat");
    push(2, 8'h00, "R1 data"); push(3, 8'h00, "R1 pins");
    drain();

    // R6 load and MSB on sdo
    wr(2'd2, 8'hA5);
    push(2, 8'hA5, "R6 load"); push(3, 8'h01, "R6 sdo msb");
    drain();

    // R2 toggle, R8 readback
    wr(2'd0, 8'h11);
    push(3, 8'h03, "R2 sck high"); push(1, 8'h01, "R2 count");
    push(0, 8'h10, "R8 ctrl readback");
    drain();

    // R5 shift strobe alone ignored
    wr(2'd0, 8'h12);
    push(2, 8'hA5, "R5 data held"); push(3, 8'h03, "R5 sck held");
    push(1, 8'h01, "R5 count held");
    drain();

    // R9 wrong mode / wrong source ignored
    wr(2'd0, 8'h01);
    push(3, 8'h03, "R9 mode00 sck"); push(1, 8'h01, "R9 mode00 count");
    drain();
    wr(2'd0, 8'h17);
    push(3, 8'h03, "R9 src01 sck"); push(2, 8'hA5, "R9 src01 data");
    push(0, 8'h14, "R8 mode/src kept");
    drain();
    wr(2'd0, 8'h10);

    // R3 wrap and R4 flag handling
    wr(2'd1, 8'h0F);
    push(1, 8'h0F, "R4 count load");
    drain();
    wr(2'd0, 8'h11);
    push(1, 8'h80, "R3 wrap flag"); push(3, 8'h01, "R2 sck low");
    drain();
    wr(2'd1, 8'h05);
    push(1, 8'h85, "R4 flag kept");
    drain();
    wr(2'd1, 8'h80);
    push(1, 8'h00, "R4 flag cleared");
    drain();

    // R6/R7 full exchange
    tx = 8'hA5; rx = 8'h3C;
    wr(2'd2, tx);
    for (int i = 7; i >= 0; i--) begin
      sdi = rx[i];
      push(3, {7'b0, tx[i]}, "R6 sdo bit");
      drain();
      wr(2'd0, 8'h11);
      wr(2'd0, 8'h13);
    end
    push(2, rx, "R7 received byte"); push(1, 8'h80, "R3 byte overflow");
    push(3, 8'h00, "R7 end pins");
    drain();

    // R10 clock shape with writes every second cycle
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h00);
    sdi = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = (k % 2 == 0) ? 8'h11 : 8'h13;
      if (k > 0) push(4, (k % 2 == 0) ? 8'h00 : 8'h01, "R10 sck second half");
      @(negedge clk);
      wr_en = 1'b0;
      push(4, (k % 2 == 0) ? 8'h01 : 8'h00, "R10 sck first half");
    end
    @(negedge clk);
    push(4, 8'h00, "R10 sck held low");
    drain();
    push(2, 8'hFF, "R7 ones shifted in"); push(1, 8'h80, "R3 second wrap");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule